// File: doc/BRIEF.md
# Ethernet destination address filter with group hash table

This block makes the receive-side accept/reject decision for an Ethernet frame from its 48-bit destination address. The address arrives one byte per strobe, first byte first. While the bytes arrive, the block folds them into a CRC-32. Once the sixth byte is in, it classifies the address as broadcast, individual (unicast) or group (multicast).

An individual address is accepted only if it equals the programmed station address. A group address is accepted if the entry selected by the top eight CRC bits is set in a 256-entry hash table. The broadcast address is always accepted. A promiscuous control bit accepts whatever the other rules reject.

Software programs the station address, the eight 32-bit hash words and the control bit through a simple write port. The same port has a combinational read-back. Frame parsing, FCS checking and the rest of the MAC are handled elsewhere. A one-cycle decision pulse reports whether the frame is accepted and which rule matched.

Top module: `mac_dest_filter`

## Requirements
- R1: Destination bytes are taken on cycles with `da_valid` high, idle cycles between them allowed. If the sixth byte is sampled at clock edge N, `dec_valid` is high for exactly the one cycle after edge N+1, and low otherwise.
- R2: A byte with `da_first` high is taken as byte 0 of a new address, and any partly collected address is dropped without producing a decision.
- R3: The address FF:FF:FF:FF:FF:FF is accepted with kind 2 (broadcast), whatever the other settings.
- R4: An address whose first byte has bit 0 clear is accepted with kind 1 (station) only if all six bytes equal the station address. For station bytes b0..b5 in arrival order, register 8 holds {b5,b4,b3,b2} (b5 in bits 31:24) and register 9 bits 31:16 hold {b1,b0}.
- R5: For an address whose first byte has bit 0 set (and is not broadcast), a CRC-32 is formed. It uses polynomial 0x04C11DB7 and starts from all ones. Each byte is fed least significant bit first, and the result is not inverted. Its top 8 bits form an index i. The frame is accepted with kind 3 (hash) if bit (31 - i[4:0]) of hash register i[7:5] (registers 0..7) is set.
- R6: With the promiscuous bit (register 10, bit 3) set, a frame that no other rule accepts is accepted with kind 4. Frames that another rule accepts keep that rule's kind.
- R7: A rejected frame reports `dec_accept` low and kind 0.
- R8: After reset, all hash words, the station address and the promiscuous bit are zero and `dec_valid` is low, so no group frame is accepted.
- R9: Reads are combinational from `cfg_addr`. Registers 0..8 return the value written. Register 9 returns the written bits 31:16 with bits 15:0 zero. Register 10 returns only bit 3. Addresses 11..15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| da_valid | input | 1 | Destination byte valid |
| da_first | input | 1 | Marks byte 0 of a destination address |
| da_byte | input | 8 | Destination byte, arrival order |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 3 | 0 none, 1 station, 2 broadcast, 3 hash, 4 promiscuous |

## Verification
The decision is due two edges after the edge that samples the sixth byte. The bench drives inputs on falling edges and samples on falling edges. It checks that `dec_valid` is still low one falling edge after the last byte, that it is high together with the expected accept and kind on the next one, and that it is low again on the one after. Register writes take effect at the next rising edge, and read-back is checked combinationally one step after `cfg_addr` is set. Runs with idle gaps and with a restart keep the same count from the sixth byte actually taken.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

    localparam int DA_BYTES    = 6;
    localparam int BYTE_W      = 8;
    localparam int DA_W        = DA_BYTES * BYTE_W;

    localparam int REG_STN_HI  = 8;
    localparam int REG_STN_LO  = 9;
    localparam int REG_CTRL    = 10;
    localparam int PROMISC_BIT = 3;

    typedef enum logic [2:0] {
        MK_NONE    = 3'd0,
        MK_STATION = 3'd1,
        MK_BCAST   = 3'd2,
        MK_HASH    = 3'd3,
        MK_PROMISC = 3'd4
    } match_kind_e;

endpackage

// File: rtl/mdf_regs.sv
module mdf_regs
    import mdf_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int HASH_WORDS = 8,
    parameter int CFG_AW     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]            cfg_wdata,
    output logic [WORD_W-1:0]            cfg_rdata,
    output logic [DA_W-1:0]              station,
    output logic                         promisc,
    output logic [WORD_W*HASH_WORDS-1:0] hash_tbl
);

    localparam int TBL_BITS = WORD_W * HASH_WORDS;
    localparam int SEL_W    = $clog2(HASH_WORDS);
    localparam logic [CFG_AW-1:0] ADR_HI   = CFG_AW'(REG_STN_HI);
    localparam logic [CFG_AW-1:0] ADR_LO   = CFG_AW'(REG_STN_LO);
    localparam logic [CFG_AW-1:0] ADR_CTRL = CFG_AW'(REG_CTRL);

    typedef struct packed {
        logic [HASH_WORDS-1:0][WORD_W-1:0] hash;
        logic [31:0]                       stn_hi;
        logic [15:0]                       stn_lo;
        logic                              promisc;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hash_sel;

    assign hash_sel = (cfg_addr[CFG_AW-1:SEL_W] == '0);

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (hash_sel) begin
                st_d.hash[cfg_addr[SEL_W-1:0]] = cfg_wdata;
            end else if (cfg_addr == ADR_HI) begin
                st_d.stn_hi = cfg_wdata[31:0];
            end else if (cfg_addr == ADR_LO) begin
                st_d.stn_lo = cfg_wdata[31:16];
            end else if (cfg_addr == ADR_CTRL) begin
                st_d.promisc = cfg_wdata[PROMISC_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (hash_sel) begin
            cfg_rdata = st_q.hash[cfg_addr[SEL_W-1:0]];
        end else if (cfg_addr == ADR_HI) begin
            cfg_rdata = st_q.stn_hi;
        end else if (cfg_addr == ADR_LO) begin
            cfg_rdata = {st_q.stn_lo, 16'h0000};
        end else if (cfg_addr == ADR_CTRL) begin
            cfg_rdata[PROMISC_BIT] = st_q.promisc;
        end
    end

    // byte 0 of the address sits in the top byte of the vector
    assign station = {st_q.stn_lo[7:0],   st_q.stn_lo[15:8],
                      st_q.stn_hi[7:0],   st_q.stn_hi[15:8],
                      st_q.stn_hi[23:16], st_q.stn_hi[31:24]};
    assign promisc = st_q.promisc;

    // entry e lives MSB-first inside word e/WORD_W
    for (genvar e = 0; e < TBL_BITS; e++) begin : g_tbl
        assign hash_tbl[e] = st_q.hash[e / WORD_W][WORD_W - 1 - (e % WORD_W)];
    end

    // R9: a hash write lands in the addressed word at the next edge
    a_r9_hash_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && hash_sel) |=> (st_q.hash[$past(cfg_addr[SEL_W-1:0])] == $past(cfg_wdata)));

    // R9: writes outside the map leave every register untouched
    a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !hash_sel && cfg_addr != ADR_HI && cfg_addr != ADR_LO && cfg_addr != ADR_CTRL)
        |=> (st_q == $past(st_q)));

endmodule

// File: rtl/mdf_collect.sv
module mdf_collect
    import mdf_pkg::*;
#(
    parameter logic [31:0] CRC_POLY = 32'h04C11DB7,
    parameter int          IDX_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_valid,
    input  logic              da_first,
    input  logic [BYTE_W-1:0] da_byte,
    output logic              s1_valid,
    output logic [DA_W-1:0]   s1_addr,
    output logic [IDX_W-1:0]  s1_idx
);

    localparam int CNT_W = $clog2(DA_BYTES);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DA_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]                   cnt;
        logic [31:0]                        crc;
        logic [DA_BYTES-1:0][BYTE_W-1:0]    bytes;
        logic                               done;
    } col_state_t;

    col_state_t       cs_d, cs_q;
    logic [CNT_W-1:0] pos;
    logic [31:0]      seed;

    function automatic logic [31:0] crc_fold(input logic [31:0] c_in, input logic [BYTE_W-1:0] b);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int j = 0; j < BYTE_W; j++) begin
            fb = c[31] ^ b[j];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    always_comb begin
        cs_d      = cs_q;
        cs_d.done = 1'b0;
        pos       = da_first ? '0 : cs_q.cnt;
        seed      = (pos == '0) ? 32'hFFFF_FFFF : cs_q.crc;
        if (da_valid) begin
            cs_d.crc        = crc_fold(seed, da_byte);
            cs_d.bytes[pos] = da_byte;
            if (pos == LAST_POS) begin
                cs_d.cnt  = '0;
                cs_d.done = 1'b1;
            end else begin
                cs_d.cnt = pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign s1_valid = cs_q.done;
    assign s1_idx   = cs_q.crc[31 -: IDX_W];

    for (genvar k = 0; k < DA_BYTES; k++) begin : g_addr
        assign s1_addr[DA_W - 1 - k*BYTE_W -: BYTE_W] = cs_q.bytes[k];
    end

    // R1: a completed address always follows an accepted byte
    a_r1_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(da_valid));

    // R2: a restart can never complete on the next cycle
    a_r2_restart_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && da_first) |=> !s1_valid);

endmodule

// File: rtl/mdf_decide.sv
module mdf_decide
    import mdf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s1_valid,
    input  logic [DA_W-1:0]       s1_addr,
    input  logic [IDX_W-1:0]      s1_idx,
    input  logic [DA_W-1:0]       station,
    input  logic                  promisc,
    input  logic [2**IDX_W-1:0]   hash_tbl,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output match_kind_e           dec_kind
);

    typedef struct packed {
        logic        valid;
        logic        accept;
        match_kind_e kind;
    } dec_state_t;

    dec_state_t ds_d, ds_q;
    logic       is_group, is_bcast, stn_hit, tbl_hit;

    assign is_group = s1_addr[DA_W - BYTE_W];
    assign is_bcast = &s1_addr;
    assign stn_hit  = (s1_addr == station);
    assign tbl_hit  = hash_tbl[s1_idx];

    always_comb begin
        ds_d       = ds_q;
        ds_d.valid = s1_valid;
        if (s1_valid) begin
            ds_d.accept = 1'b1;
            if (is_bcast)                 ds_d.kind = MK_BCAST;
            else if (!is_group && stn_hit) ds_d.kind = MK_STATION;
            else if (is_group && tbl_hit)  ds_d.kind = MK_HASH;
            else if (promisc)              ds_d.kind = MK_PROMISC;
            else begin
                ds_d.accept = 1'b0;
                ds_d.kind   = MK_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ds_q <= '{valid: 1'b0, accept: 1'b0, kind: MK_NONE};
        else        ds_q <= ds_d;
    end

    assign dec_valid  = ds_q.valid;
    assign dec_accept = ds_q.accept;
    assign dec_kind   = ds_q.kind;

    // R1: the decision is a single-cycle pulse
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R3: broadcast from the collector is accepted as broadcast next cycle
    a_r3_bcast_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && is_bcast) |=> (dec_valid && dec_accept && dec_kind == MK_BCAST));

    // R7: reject goes with kind none, accept with any other kind
    a_r7_reject_kind: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_kind != MK_NONE)));

    // R4: an individual address is never reported as a hash match
    a_r4_unicast_not_hash: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !is_group) |=> (dec_kind != MK_HASH));

endmodule

// File: rtl/mac_dest_filter.sv
module mac_dest_filter
    import mdf_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter int          HASH_WORDS = 8,
    parameter int          CFG_AW     = 4,
    parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              da_valid,
    input  logic              da_first,
    input  logic [7:0]        da_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_kind
);

    localparam int TBL_BITS = WORD_W * HASH_WORDS;
    localparam int IDX_W    = $clog2(TBL_BITS);

    logic [DA_W-1:0]     station;
    logic                promisc;
    logic [TBL_BITS-1:0] hash_tbl;
    logic                s1_valid;
    logic [DA_W-1:0]     s1_addr;
    logic [IDX_W-1:0]    s1_idx;
    match_kind_e         kind;

    mdf_regs #(
        .WORD_W     (WORD_W),
        .HASH_WORDS (HASH_WORDS),
        .CFG_AW     (CFG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .station   (station),
        .promisc   (promisc),
        .hash_tbl  (hash_tbl)
    );

    mdf_collect #(
        .CRC_POLY (CRC_POLY),
        .IDX_W    (IDX_W)
    ) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .da_valid (da_valid),
        .da_first (da_first),
        .da_byte  (da_byte),
        .s1_valid (s1_valid),
        .s1_addr  (s1_addr),
        .s1_idx   (s1_idx)
    );

    mdf_decide #(
        .IDX_W (IDX_W)
    ) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_addr    (s1_addr),
        .s1_idx     (s1_idx),
        .station    (station),
        .promisc    (promisc),
        .hash_tbl   (hash_tbl),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_kind   (kind)
    );

    assign dec_kind = kind;

endmodule

// File: tb/sim_mac_dest_filter.sv
`timescale 1ns/1ps
module sim_mac_dest_filter;

    localparam logic [31:0] POLY = 32'h04C11DB7;
    localparam logic [47:0] STN  = 48'h02A0C41577E9;
    localparam logic [47:0] G1   = 48'h01005E0000FB;
    localparam logic [47:0] G3   = 48'h01005E123456;
    localparam int NV = 12;
    // each entry: {destination, promiscuous}
    localparam logic [48:0] VEC [NV] = '{
        {48'hFFFFFFFFFFFF, 1'b0},
        {STN,              1'b0},
        {48'h02A0C41577E8, 1'b0},
        {48'h0A1B2C3D4E5F, 1'b0},
        {G1,               1'b0},
        {48'h01005E7F1122, 1'b0},
        {48'hFFFFFFFFFFFE, 1'b0},
        {G1,               1'b1},
        {48'h0A1B2C3D4E5F, 1'b1},
        {STN,              1'b1},
        {48'h333300000001, 1'b1},
        {48'hFFFFFFFFFFFF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        da_valid = 1'b0;
    logic        da_first = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_hash [8];
    logic        m_prom;
    logic [47:0] m_stn;

    always #5 clk = ~clk;

    mac_dest_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .da_valid(da_valid),
        .da_first(da_first), .da_byte(da_byte), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_kind(dec_kind)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = da[47 - 8*k -: 8];
            for (int j = 0; j < 8; j++) begin
                logic top = c[31];
                c = c << 1;
                if (top != b[j]) c = c ^ POLY;
            end
        end
        return c;
    endfunction

    function automatic logic [3:0] expect_of(input logic [47:0] da);
        logic [7:0] i = ref_crc(da)[31:24];
        logic hit = m_hash[i[7:5]][31 - i[4:0]];
        if (da == 48'hFFFFFFFFFFFF) return {1'b1, 3'd2};
        if (!da[40] && da == m_stn) return {1'b1, 3'd1};
        if (da[40] && hit)          return {1'b1, 3'd3};
        if (m_prom)                 return {1'b1, 3'd4};
        return {1'b0, 3'd0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic set_prom(input logic p);
        wr(4'd10, {28'd0, p, 3'b000});
        m_prom = p;
    endtask

    task automatic set_hash_bit(input logic [47:0] da);
        logic [7:0] i = ref_crc(da)[31:24];
        m_hash[i[7:5]] = m_hash[i[7:5]] | (32'h1 << (31 - i[4:0]));
        wr({1'b0, i[7:5]}, m_hash[i[7:5]]);
    endtask

    // sends one address and checks the R1 timing plus the decision
    task automatic run_da(input string tag, input logic [47:0] da, input int gap);
        logic [3:0] ex = expect_of(da);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            da_valid = 1'b1; da_first = (k == 0); da_byte = da[47 - 8*k -: 8];
            if (k < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    da_valid = 1'b0;
                    check("R1 no decision mid-address", {31'd0, dec_valid}, 32'd0);
                end
            end
        end
        @(negedge clk);
        da_valid = 1'b0; da_first = 1'b0;
        check("R1 not yet valid", {31'd0, dec_valid}, 32'd0);
        @(negedge clk);
        check("R1 valid on time", {31'd0, dec_valid}, 32'd1);
        check({tag, " accept"}, {31'd0, dec_accept}, {31'd0, ex[3]});
        check({tag, " kind"}, {29'd0, dec_kind}, {29'd0, ex[2:0]});
        @(negedge clk);
        check("R1 single pulse", {31'd0, dec_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 8; w++) m_hash[w] = '0;
        m_prom = 1'b0;
        m_stn  = '0;
        repeat (3) @(negedge clk);
        check("R8 no decision in reset", {31'd0, dec_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 no decision after reset", {31'd0, dec_valid}, 32'd0);
        for (int w = 0; w < 11; w++) rd_check("R8 register zero", w[3:0], 32'd0);
        run_da("R8 group rejected after reset", G1, 0);

        // station b0..b5 = 02 A0 C4 15 77 E9
        wr(4'd8, 32'hE97715C4);
        wr(4'd9, 32'hA0020000);
        m_stn = STN;
        rd_check("R9 station high", 4'd8, 32'hE97715C4);
        rd_check("R9 station low", 4'd9, 32'hA0020000);
        set_hash_bit(G1);

        // R3 R4 R5 R6 R7 walked from the vector table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][0] != m_prom) set_prom(VEC[v][0]);
            run_da($sformatf("R3/R4/R5/R6/R7 vector %0d", v), VEC[v][48:1], 0);
        end
        set_prom(1'b0);

        // R1 idle gaps between bytes
        run_da("R1 gapped station", STN, 2);

        // R2 restart drops a partial address
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            da_valid = 1'b1; da_first = (k == 0); da_byte = 8'hFF;
        end
        @(negedge clk);
        da_valid = 1'b0;
        check("R2 partial gives no decision", {31'd0, dec_valid}, 32'd0);
        run_da("R2 restart station", STN, 0);

        // R5 bit order within a word: mirrored bit must not match
        begin
            logic [7:0] i3 = ref_crc(G3)[31:24];
            m_hash[i3[7:5]] = 32'h1 << i3[4:0];
            wr({1'b0, i3[7:5]}, m_hash[i3[7:5]]);
            run_da("R5 mirrored bit", G3, 0);
            check("R5 mirrored bit rejects", {31'd0, dec_accept}, 32'd0);
            m_hash[i3[7:5]] = 32'h1 << (31 - i3[4:0]);
            wr({1'b0, i3[7:5]}, m_hash[i3[7:5]]);
            run_da("R5 correct bit", G3, 0);
            check("R5 correct bit accepts", {31'd0, dec_accept}, 32'd1);
            rd_check("R9 hash word read", {1'b0, i3[7:5]}, m_hash[i3[7:5]]);
        end

        // R9 read formats and unmapped space
        wr(4'd9, 32'hFFFFFFFF);
        rd_check("R9 low half reads zero", 4'd9, 32'hFFFF0000);
        wr(4'd9, 32'hA0020000);
        wr(4'd10, 32'hFFFFFFFF);
        rd_check("R9 control only bit 3", 4'd10, 32'h00000008);
        wr(4'd10, 32'h0);
        wr(4'd11, 32'hDEADBEEF);
        rd_check("R9 unmapped reads zero", 4'd11, 32'd0);
        wr(4'd15, 32'hFFFFFFFF);
        rd_check("R9 unmapped top reads zero", 4'd15, 32'd0);
        rd_check("R9 station kept", 4'd8, 32'hE97715C4);
        rd_check("R9 control kept", 4'd10, 32'd0);
        run_da("R9 station still matches", STN, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule